// File: doc/BRIEF.md
# Serial Flash Status and Write-Guard Controller

This block is the status register and write-protection logic of a serial flash slave. It holds a hardware-lock bit, a three-bit protection level, a volatile write-enable latch and a busy flag. Every request to program, erase or rewrite the status register is checked against these bits and an external lock pin. The block then grants, denies or silently drops the request. A granted operation raises the busy flag for a parameterized number of cycles, which stands in for the internal operation time.

The command decoder in front of the block presents one request per cycle: an operation code, a byte address and a data byte. It gets back a one-cycle grant or deny pulse. In parallel, a host can read the status byte at any time through a select / serial-clock / data-out shift port. The read works even while an operation is running.

The protection level selects a range of 64 KB blocks anchored at the top of a 4 Mbit array of 8 blocks. The address is 19 bits wide and its top three bits, [18:16], pick the block. The lock bit and the protection level model non-volatile storage, so reset does not clear them.

Top module: `sflash_guard`

## Requirements
- R1: Synchronous active-low reset clears the write-enable latch and the busy flag. It leaves the lock bit and the protection level unchanged, and both power up as 0.
- R2: The status byte is {lock bit, 0, 0, protection level[2:0], write-enable latch, busy}, with the lock bit in bit 7 and busy in bit 0. The `busy` port equals bit 0.
- R3: Operation codes are: 0 = arm, 1 = disarm, 2 = page program, 3 = sector erase, 4 = block erase, 5 = chip erase, 6 = status write, 7 = no effect. When idle, arm sets the write-enable latch and disarm clears it. Neither produces a grant or a deny.
- R4: A program, erase or status write is denied while the write-enable latch is 0, and the status byte is left unchanged.
- R5: Level 0 guards no block. Level 1 guards block 7, level 2 guards blocks 6 and 7, level 3 guards blocks 4 to 7, and levels 4 to 7 guard every block. An enabled program, sector erase or block erase that targets a guarded block is denied and clears the write-enable latch. Otherwise it is granted.
- R6: An enabled chip erase is granted only at level 0. At any other level it is denied and clears the write-enable latch.
- R7: When the lock bit is 1 and `lockPinN` is low, a status write produces neither grant nor deny and changes nothing. With `lockPinN` high, it is processed normally.
- R8: A grant sets busy on the same clock edge. Busy then stays high for exactly BUSY_CYCLES cycles and clears together with the write-enable latch. A granted status write loads the lock bit from data bit 7 and the level from data bits 4..2 when busy clears.
- R9: While busy is 1, every request is dropped: no grant, no deny, no change of state.
- R10: Falling `selN` captures the status byte and presents bit 7 on `serOut`. Each falling `serClk` edge with `selN` low moves to the next lower bit. After bit 0, the next falling edge recaptures a fresh byte, so reads repeat for as long as `selN` stays low. `serOut` is 0 while `selN` is high.
- R11: A grant or deny is a single-cycle pulse, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | Request strobe |
| reqOp | input | 3 | Operation code (R3) |
| reqAddr | input | 19 | Target byte address; bits [18:16] select the block |
| reqData | input | 8 | New status value for a status write |
| lockPinN | input | 1 | External write-lock pin, active low |
| selN | input | 1 | Status read select, active low |
| serClk | input | 1 | Status read shift clock, sampled by clk |
| reqGrant | output | 1 | Request accepted pulse |
| reqDeny | output | 1 | Request refused pulse |
| busy | output | 1 | Operation in progress |
| serOut | output | 1 | Status read serial data |

## Verification
The bench builds the block with the default 19-bit address and 8 blocks, so every protection level and every block rank is reachable from random addresses. It overrides BUSY_CYCLES to 6. With that value, a request and a full status read can both be placed inside the busy window, and the busy length can be counted exactly. Together these cover the dropped-request case, the status snapshot taken during an operation, and hundreds of random operations in a short run.

// File: rtl/sg_pkg.sv
package sg_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  typedef enum logic [2:0] {
    OP_ARM          = 3'd0,
    OP_DISARM       = 3'd1,
    OP_PROGRAM      = 3'd2,
    OP_SECTOR_ERASE = 3'd3,
    OP_BLOCK_ERASE  = 3'd4,
    OP_CHIP_ERASE   = 3'd5,
    OP_WRITE_STATUS = 3'd6,
    OP_NONE         = 3'd7
  } guard_op_t;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic setWip;
    logic clrWip;
    logic stageStatus;
    logic commitStatus;
  } guard_strobe_t;
endpackage

// File: rtl/sg_datapath.sv
module sg_datapath
  import sg_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int BLOCK_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  guard_strobe_t     strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  input  logic              selN,
  input  logic              serClk,
  output logic [7:0]        statusByte,
  output logic              welBit,
  output logic              wipBit,
  output logic              srwdBit,
  output logic              addrProtected,
  output logic              bpZero,
  output logic              serOut
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NUM_BLOCKS = 1 << BLOCK_W;
  localparam int SPAN_W     = BLOCK_W + 1;

  // non-volatile model bits: no reset
  logic       lockR  = 1'b0;
  logic [2:0] levelR = 3'b000;
  logic       pendLock;
  logic [2:0] pendLevel;
  logic       welR, wipR;

  always_ff @(posedge clk) begin
    if (rstN && strobe.commitStatus) begin
      lockR  <= pendLock;
      levelR <= pendLevel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendLock  <= 1'b0;
      pendLevel <= 3'b000;
      welR      <= 1'b0;
      wipR      <= 1'b0;
    end else begin
      if (strobe.stageStatus) begin
        pendLock  <= reqData[7];
        pendLevel <= reqData[4:2];
      end
      if (strobe.setWel)      welR <= 1'b1;
      else if (strobe.clrWel) welR <= 1'b0;
      if (strobe.setWip)      wipR <= 1'b1;
      else if (strobe.clrWip) wipR <= 1'b0;
    end
  end

  // number of top-anchored blocks covered by the level
  logic [SPAN_W-1:0] span;
  always_comb begin
    if (levelR == 3'd0)             span = '0;
    else if (int'(levelR) > BLOCK_W) span = SPAN_W'(NUM_BLOCKS);
    else                            span = SPAN_W'(1) << (levelR - 3'd1);
  end

  logic [NUM_BLOCKS-1:0] lockMap;
  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_block
    assign lockMap[b] = SPAN_W'(NUM_BLOCKS - b) <= span;
  end

  logic [BLOCK_W-1:0] blockIdx;
  assign blockIdx      = reqAddr[ADDR_W-1 -: BLOCK_W];
  assign addrProtected = lockMap[blockIdx];
  assign bpZero        = (levelR == 3'd0);

  assign statusByte = {lockR, 2'b00, levelR, welR, wipR};
  assign welBit     = welR;
  assign wipBit     = wipR;
  assign srwdBit    = lockR;

  // status read shifter
  logic       selQ, clkQ;
  logic [7:0] shifter;
  logic [2:0] bitPos;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ    <= 1'b1;
      clkQ    <= 1'b0;
      shifter <= '0;
      bitPos  <= '0;
    end else begin
      selQ <= selN;
      clkQ <= serClk;
      if (!selN && selQ) begin
        shifter <= statusByte;
        bitPos  <= '0;
      end else if (!selN && clkQ && !serClk) begin
        if (bitPos == 3'd7) begin
          shifter <= statusByte;
          bitPos  <= '0;
        end else begin
          shifter <= {shifter[6:0], 1'b0};
          bitPos  <= bitPos + 3'd1;
        end
      end
    end
  end

  assign serOut = !selN && shifter[7];
endmodule

// File: rtl/sg_control.sv
module sg_control
  import sg_pkg::*;
#(
  parameter int BUSY_CYCLES = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [2:0]    reqOp,
  input  logic          lockPinN,
  input  logic          welBit,
  input  logic          wipBit,
  input  logic          srwdBit,
  input  logic          addrProtected,
  input  logic          bpZero,
  output guard_strobe_t strobe,
  output logic          reqGrant,
  output logic          reqDeny
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] remain;
  logic             wsPending;
  logic             accept, refuse, opDone, isWs;

  always_comb begin
    strobe = '0;
    accept = 1'b0;
    refuse = 1'b0;
    isWs   = 1'b0;
    opDone = wipBit && (remain == '0);
    if (opDone) begin
      strobe.clrWip       = 1'b1;
      strobe.clrWel       = 1'b1;
      strobe.commitStatus = wsPending;
    end else if (!wipBit && reqValid) begin
      case (guard_op_t'(reqOp))
        OP_ARM:    strobe.setWel = 1'b1;
        OP_DISARM: strobe.clrWel = 1'b1;
        OP_PROGRAM, OP_SECTOR_ERASE, OP_BLOCK_ERASE: begin
          if (!welBit) refuse = 1'b1;
          else if (addrProtected) begin
            refuse        = 1'b1;
            strobe.clrWel = 1'b1;
          end else accept = 1'b1;
        end
        OP_CHIP_ERASE: begin
          if (!welBit) refuse = 1'b1;
          else if (!bpZero) begin
            refuse        = 1'b1;
            strobe.clrWel = 1'b1;
          end else accept = 1'b1;
        end
        OP_WRITE_STATUS: begin
          if (!(srwdBit && !lockPinN)) begin
            if (!welBit) refuse = 1'b1;
            else begin
              accept             = 1'b1;
              isWs               = 1'b1;
              strobe.stageStatus = 1'b1;
            end
          end
        end
        default: ;
      endcase
      strobe.setWip = accept;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain    <= '0;
      wsPending <= 1'b0;
      reqGrant  <= 1'b0;
      reqDeny   <= 1'b0;
    end else begin
      reqGrant <= accept;
      reqDeny  <= refuse;
      if (accept) begin
        remain    <= CNT_W'(BUSY_CYCLES - 1);
        wsPending <= isWs;
      end else if (opDone) begin
        wsPending <= 1'b0;
      end else if (wipBit) begin
        remain <= remain - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sflash_guard.sv
module sflash_guard
  import sg_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int BLOCK_W     = 3,
  parameter int BUSY_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  input  logic              lockPinN,
  input  logic              selN,
  input  logic              serClk,
  output logic              reqGrant,
  output logic              reqDeny,
  output logic              busy,
  output logic              serOut
);
  timeunit 1ns;
  timeprecision 100ps;

  guard_strobe_t strobe;
  logic [7:0]    statusByte;
  logic          welBit, wipBit, srwdBit, addrProtected, bpZero;

  sg_control #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .lockPinN(lockPinN), .welBit(welBit), .wipBit(wipBit),
    .srwdBit(srwdBit), .addrProtected(addrProtected), .bpZero(bpZero),
    .strobe(strobe), .reqGrant(reqGrant), .reqDeny(reqDeny)
  );

  sg_datapath #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqData(reqData), .selN(selN), .serClk(serClk),
    .statusByte(statusByte), .welBit(welBit), .wipBit(wipBit),
    .srwdBit(srwdBit), .addrProtected(addrProtected), .bpZero(bpZero),
    .serOut(serOut)
  );

  assign busy = wipBit;
endmodule

// File: rtl/sg_checker.sv
module sg_checker
  import sg_pkg::*;
#(
  parameter int BUSY_CYCLES = 64
) (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic [2:0] reqOp,
  input logic       lockPinN,
  input logic       selN,
  input logic       reqGrant,
  input logic       reqDeny,
  input logic       serOut,
  input logic [7:0] statusByte
);
  timeunit 1ns;
  timeprecision 100ps;

  int runLen;
  always_ff @(posedge clk) begin
    if (!rstN)              runLen <= 0;
    else if (statusByte[0]) runLen <= runLen + 1;
    else                    runLen <= 0;
  end

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(reqGrant && reqDeny));
  a_r11_grant_single: assert property (@(posedge clk) disable iff (!rstN)
    reqGrant |=> !reqGrant);
  a_r9_quiet_busy: assert property (@(posedge clk) disable iff (!rstN)
    (reqGrant || reqDeny) |-> !$past(statusByte[0]));
  a_r8_busy_with_grant: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[0]) |-> reqGrant);
  a_r8_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusByte[0]) |-> runLen == BUSY_CYCLES);
  a_r8_done_clears_wel: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusByte[0]) |-> !statusByte[1]);
  a_r4_grant_needs_wel: assert property (@(posedge clk) disable iff (!rstN)
    reqGrant |-> $past(statusByte[1]));
  a_r5_deny_clears_wel: assert property (@(posedge clk) disable iff (!rstN)
    (reqDeny && $past(statusByte[1])) |-> !statusByte[1]);
  a_r6_chip_level: assert property (@(posedge clk) disable iff (!rstN)
    (reqGrant && $past(reqValid && reqOp == OP_CHIP_ERASE)) |-> $past(statusByte[4:2]) == 3'd0);
  a_r7_lock_silent: assert property (@(posedge clk) disable iff (!rstN)
    $past(reqValid && reqOp == OP_WRITE_STATUS && statusByte[7] && !lockPinN)
      |-> (!reqGrant && !reqDeny));
  a_r10_idle_line: assert property (@(posedge clk) disable iff (!rstN)
    selN |-> !serOut);
endmodule

bind sflash_guard sg_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
  .lockPinN(lockPinN), .selN(selN), .reqGrant(reqGrant), .reqDeny(reqDeny),
  .serOut(serOut), .statusByte(statusByte)
);

// File: tb/sflash_guard_bench.sv
module sflash_guard_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int BUSY = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqOp = 3'd7;
  logic [18:0] reqAddr = '0;
  logic [7:0]  reqData = '0;
  logic        lockPinN = 1'b1;
  logic        selN = 1'b1;
  logic        serClk = 1'b0;
  logic        reqGrant, reqDeny, busy, serOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic       lockM = 1'b0;
  logic [2:0] levelM = 3'd0;
  logic       welM = 1'b0;

  always #2.5 clk = ~clk;

  sflash_guard #(.BUSY_CYCLES(BUSY)) u_sflash_guard (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .lockPinN(lockPinN),
    .selN(selN), .serClk(serClk), .reqGrant(reqGrant), .reqDeny(reqDeny),
    .busy(busy), .serOut(serOut)
  );

  function automatic logic [7:0] modelStatus();
    return {lockM, 2'b00, levelM, welM, 1'b0};
  endfunction

  function automatic bit guarded(input logic [2:0] lvl, input logic [18:0] a);
    case (lvl)
      3'd0:    return 1'b0;
      3'd1:    return a[18:16] == 3'd7;
      3'd2:    return a[18:16] >= 3'd6;
      3'd3:    return a[18:16] >= 3'd4;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string opTag(input logic [2:0] op);
    case (op)
      3'd2, 3'd3, 3'd4: return "R5";
      3'd5:             return "R6";
      3'd6:             return "R7";
      default:          return "R3";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reads 16 serial bits: two consecutive status bytes
  task automatic readStatus(output logic [15:0] bits);
    selN = 1'b0;
    @(negedge clk);
    bits[15] = serOut;
    for (int i = 14; i >= 0; i--) begin
      serClk = 1'b1;
      @(negedge clk);
      serClk = 1'b0;
      @(negedge clk);
      bits[i] = serOut;
    end
    selN = 1'b1;
    @(negedge clk);
  endtask

  task automatic checkStatus(input string tag);
    logic [15:0] rd;
    readStatus(rd);
    check(rd[15:8] == modelStatus(), tag, rd[15:8], modelStatus());
  endtask

  task automatic runOp(input logic [2:0] op, input logic [18:0] addr,
                       input logic [7:0] data, input string tag);
    int expO;
    logic g, d;
    int n;
    expO = 0;
    case (op)
      3'd0: welM = 1'b1;
      3'd1: welM = 1'b0;
      3'd2, 3'd3, 3'd4: begin
        if (!welM) expO = 2;
        else if (guarded(levelM, addr)) begin expO = 2; welM = 1'b0; end
        else expO = 1;
      end
      3'd5: begin
        if (!welM) expO = 2;
        else if (levelM != 3'd0) begin expO = 2; welM = 1'b0; end
        else expO = 1;
      end
      3'd6: begin
        if (lockM && !lockPinN) expO = 0;
        else if (!welM) expO = 2;
        else expO = 1;
      end
      default: ;
    endcase
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = addr; reqData = data;
    @(negedge clk);
    reqValid = 1'b0;
    g = reqGrant; d = reqDeny;
    check(!(g && d), "R11", {g, d}, 0);
    check(g == (expO == 1) && d == (expO == 2), tag, {g, d}, (expO == 1) ? 2 : (expO == 2) ? 1 : 0);
    if (expO == 1) begin
      n = 0;
      while (busy && n < 1000) begin
        n++;
        @(negedge clk);
      end
      check(n == BUSY, "R8", n, BUSY);
      welM = 1'b0;
      if (op == 3'd6) begin
        lockM  = data[7];
        levelM = data[4:2];
      end
    end
  endtask

  initial begin
    logic [15:0] rd;
    logic g, d;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R2 power-up state
    check(busy == 1'b0, "R1", busy, 0);
    checkStatus("R1");

    // R4 disabled requests
    runOp(3'd2, 19'h00100, 8'h00, "R4");
    runOp(3'd6, 19'h0, 8'h1C, "R4");
    checkStatus("R4");

    // R3 arm / disarm / no-op code
    runOp(3'd0, 19'h0, 8'h0, "R3");
    checkStatus("R3");
    runOp(3'd7, 19'h0, 8'h0, "R3");
    checkStatus("R3");
    runOp(3'd1, 19'h0, 8'h0, "R3");
    checkStatus("R3");

    // R8/R9: status write, request during busy, snapshot during busy
    runOp(3'd0, 19'h0, 8'h0, "R3");
    @(negedge clk);
    reqValid = 1'b1; reqOp = 3'd6; reqData = 8'h0C;
    @(negedge clk);
    check(reqGrant == 1'b1, "R8", reqGrant, 1);
    reqOp = 3'd2; reqAddr = 19'h0;
    @(negedge clk);
    reqValid = 1'b0;
    check(!reqGrant && !reqDeny, "R9", {reqGrant, reqDeny}, 0);
    readStatus(rd);
    check(rd[15:8] == 8'h03, "R8", rd[15:8], 8'h03);
    repeat (BUSY) @(negedge clk);
    levelM = 3'd3; welM = 1'b0;
    checkStatus("R2");

    // R5 boundary at level 3
    runOp(3'd0, 19'h0, 8'h0, "R3");
    runOp(3'd2, 19'h3FFFF, 8'h0, "R5");
    runOp(3'd0, 19'h0, 8'h0, "R3");
    runOp(3'd3, 19'h40000, 8'h0, "R5");
    checkStatus("R5");

    // R6 chip erase
    runOp(3'd0, 19'h0, 8'h0, "R3");
    runOp(3'd5, 19'h0, 8'h0, "R6");
    checkStatus("R6");

    // R1 level survives reset
    runOp(3'd0, 19'h0, 8'h0, "R3");
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    welM = 1'b0;
    @(negedge clk);
    checkStatus("R1");

    // R7 hardware lock
    runOp(3'd0, 19'h0, 8'h0, "R3");
    runOp(3'd6, 19'h0, 8'h84, "R7");
    lockPinN = 1'b0;
    runOp(3'd0, 19'h0, 8'h0, "R3");
    runOp(3'd6, 19'h0, 8'h00, "R7");
    checkStatus("R7");
    lockPinN = 1'b1;
    runOp(3'd6, 19'h0, 8'h00, "R7");
    checkStatus("R7");

    // R6 chip erase at level 0
    runOp(3'd0, 19'h0, 8'h0, "R3");
    runOp(3'd5, 19'h0, 8'h0, "R6");

    // R10 continuous read and idle line
    runOp(3'd0, 19'h0, 8'h0, "R3");
    readStatus(rd);
    check(rd[15:8] == modelStatus(), "R10", rd[15:8], modelStatus());
    check(rd[7:0] == rd[15:8], "R10", rd[7:0], rd[15:8]);
    check(serOut == 1'b0, "R10", serOut, 0);

    // random mix
    for (int it = 0; it < 300; it++) begin
      logic [2:0] op;
      logic [7:0] dat;
      op  = ($urandom % 3 == 0) ? 3'd0 : 3'($urandom % 8);
      dat = 8'($urandom);
      if ($urandom % 4 != 0) dat = dat & 8'h7C;
      lockPinN = ($urandom % 4 != 0);
      runOp(op, 19'($urandom), dat, opTag(op));
      checkStatus("R2");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0h expected %0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule